// File: doc/BRIEF.md
# Memory-Resident Descriptor Transfer Engine

This block moves data between memory locations for any number of logical channels. It keeps no per-channel state inside. Each channel is described by a four-word descriptor that sits in ordinary memory. A requester pulses `start` with the byte address of a descriptor. The engine then reads the descriptor over its memory master port and copies one element or a whole block from the source address to the destination address. It finishes by writing the updated address and count words back over the descriptor.

The descriptor is four longwords placed at consecutive addresses:

- `ptr+0`: control word.
- `ptr+4`: source address.
- `ptr+8`: destination address.
- `ptr+12`: counts. Bits [15:0] are count A and bits [31:16] are count B.

The control word packs these fields:

| Bits | Field | Encoding |
|---|---|---|
| [1:0] | element size | 0 byte, 1 word, 2 longword (3 is taken as longword) |
| [3:2] | source step | 0 fixed, 1 increment, 2 decrement |
| [5:4] | destination step | same encoding as the source step |
| [7:6] | mode | 0 single, 1 cyclic, 2 block |
| [8] | wrap-side | 1 = source, 0 = destination |
| [9] | link-enable | |
| [10] | link-on-zero | |

When link-enable is set, the descriptor at `ptr+16` is processed within the same activation.

The memory port is byte addressed and 32 bits wide. Data is little-endian and sits in the low lanes. A request is held until a one-cycle acknowledge.

Top module: `xde_engine`

## Requirements
- R1: After reset, `busy` and `mem_req` are low.
- R2: A `start` seen while idle raises `busy` in the next cycle. Four longword reads are issued at `ptr`, `ptr+4`, `ptr+8` and `ptr+12`. Three longword write-backs go to `ptr+4`, `ptr+8` and `ptr+12`, and the control word is never written. `busy` falls only after the acknowledge of the final write-back.
- R3: After each element, each address steps independently by the element size (1, 2 or 4) according to its step code: 1 increments, 2 decrements, 0 leaves it fixed.
- R4: Single mode moves one element per activation and decrements the 16-bit count A. A count of 0 stands for 65536 and is written back as 0xFFFF.
- R5: Cyclic mode moves one element per activation. Count A bits [7:0] are the remaining count and bits [15:8] are the reload value, where 0 means 256. When the remaining count reaches 0, it is reloaded and the wrap-side address is moved back by reload × element size against its step direction.
- R6: Block mode moves count A bits [15:8] elements per activation, where 0 means 256. It then restores the wrap-side address to its value at the start of the block and decrements the 16-bit block count B, where 0 means 65536. Count A is written back unchanged.
- R7: With link-enable set, the descriptor at `ptr+16` is fetched and processed after the write-back, within the same activation.
- R8: With link-on-zero also set, the link is taken only if the current descriptor's counter reached zero. In single mode that is count A, in cyclic mode the remaining count, and in block mode count B.
- R9: A memory request keeps its address, direction, size and write data until acknowledged. Each acknowledge completes exactly one access, so a single-mode descriptor costs nine accesses.
- R10: `start` is ignored while `busy` is high, including in the cycle of the final write-back acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Activation request |
| start_ptr | input | ADDR_W | Byte address of the first descriptor |
| busy | output | 1 | Activation in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | 0 byte, 1 word, 2 longword |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data, low lanes |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | One-cycle access completion |

## Verification
A new `start` can arrive in the same cycle as the acknowledge that retires the last write-back. At that edge the engine's state still reads as busy, even though `busy` drops right after. The bench provokes this by watching at the falling clock edge for the acknowledge of the write to `ptr+12` and driving `start` toward a second descriptor at that moment. The request counts as correctly refused if `busy` stays low afterwards and the second descriptor's count word in memory is unchanged. The behavioural memory varies its acknowledge latency from zero to two cycles, so request holding is exercised throughout.

// File: rtl/xde_pkg.sv
package xde_pkg;
    localparam int CTL_W      = 11;
    localparam int F_SIZE_LO  = 0;
    localparam int F_SSTEP_LO = 2;
    localparam int F_DSTEP_LO = 4;
    localparam int F_MODE_LO  = 6;
    localparam int F_WRAPSRC  = 8;
    localparam int F_LINK     = 9;
    localparam int F_LINKZ    = 10;

    localparam logic [1:0] MODE_SINGLE = 2'd0;
    localparam logic [1:0] MODE_CYCLIC = 2'd1;
    localparam logic [1:0] MODE_BLOCK  = 2'd2;

    localparam logic [1:0] STEP_FIXED = 2'd0;
    localparam logic [1:0] STEP_INC   = 2'd1;
    localparam logic [1:0] STEP_DEC   = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_WBACK
    } xde_state_e;

    function automatic logic [1:0] eff_size(input logic [1:0] s);
        return (s == 2'd3) ? 2'd2 : s;
    endfunction
endpackage

// File: rtl/xde_addr_unit.sv
module xde_addr_unit import xde_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int RCNT_W = 9
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        step_i,
    input  logic [1:0]        size_i,
    input  logic              wrap_i,
    input  logic [RCNT_W-1:0] rcnt_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] delta;
    logic [ADDR_W-1:0] span;

    always_comb begin
        delta = ADDR_W'(1) << eff_size(size_i);
        span  = ADDR_W'(rcnt_i) << eff_size(size_i);
        unique case (step_i)
            STEP_INC: addr_o = wrap_i ? (addr_i + delta - span) : (addr_i + delta);
            STEP_DEC: addr_o = wrap_i ? (addr_i - delta + span) : (addr_i - delta);
            default:  addr_o = addr_i;
        endcase
    end
endmodule

// File: rtl/xde_count_unit.sv
module xde_count_unit import xde_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic [1:0]         mode_i,
    input  logic [CNT_W-1:0]   cnt_a_i,
    input  logic [CNT_W-1:0]   cnt_b_i,
    input  logic [CNT_W/2:0]   blk_i,
    output logic [CNT_W-1:0]   cnt_a_o,
    output logic [CNT_W-1:0]   cnt_b_o,
    output logic [CNT_W/2:0]   blk_o,
    output logic [CNT_W/2:0]   rcnt_o,
    output logic               wrap_o,
    output logic               zero_o,
    output logic               last_o
);
    localparam int HALF = CNT_W / 2;

    logic [HALF-1:0] hi;
    logic [HALF-1:0] lo_n;

    always_comb begin
        hi      = cnt_a_i[CNT_W-1:HALF];
        lo_n    = cnt_a_i[HALF-1:0] - 1'b1;
        rcnt_o  = (hi == '0) ? {1'b1, {HALF{1'b0}}} : {1'b0, hi};
        cnt_a_o = cnt_a_i;
        cnt_b_o = cnt_b_i;
        blk_o   = blk_i;
        wrap_o  = 1'b0;
        zero_o  = 1'b0;
        last_o  = 1'b1;
        unique case (mode_i)
            MODE_CYCLIC: begin
                if (lo_n == '0) begin
                    cnt_a_o = {hi, hi};
                    wrap_o  = 1'b1;
                    zero_o  = 1'b1;
                end else begin
                    cnt_a_o = {hi, lo_n};
                end
            end
            MODE_BLOCK: begin
                blk_o = blk_i - 1'b1;
                if (blk_o == '0) begin
                    wrap_o  = 1'b1;
                    cnt_b_o = cnt_b_i - 1'b1;
                    zero_o  = (cnt_b_o == '0);
                    blk_o   = rcnt_o;
                end else begin
                    last_o = 1'b0;
                end
            end
            default: begin
                cnt_a_o = cnt_a_i - 1'b1;
                zero_o  = (cnt_a_o == '0);
            end
        endcase
    end
endmodule

// File: rtl/xde_engine.sv
module xde_engine import xde_pkg::*; #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_ptr,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack
);
    localparam int HALF = CNT_W / 2;
    localparam int BW   = HALF + 1;

    typedef struct packed {
        xde_state_e        st;
        logic [ADDR_W-1:0] ptr;
        logic [1:0]        idx;
        logic [CTL_W-1:0]  ctl;
        logic [ADDR_W-1:0] sar;
        logic [ADDR_W-1:0] dar;
        logic [CNT_W-1:0]  cnt_a;
        logic [CNT_W-1:0]  cnt_b;
        logic [31:0]       data;
        logic [BW-1:0]     blk;
        logic              hit0;
    } eng_t;

    eng_t q, d;

    logic [1:0]        c_size, c_mode, c_sstep, c_dstep;
    logic              c_wrapsrc, link_take;
    logic [CNT_W-1:0]  u_cnt_a, u_cnt_b;
    logic [BW-1:0]     u_blk, u_rcnt;
    logic              u_wrap, u_zero, u_last;
    logic [ADDR_W-1:0] u_sar, u_dar;

    assign c_size    = eff_size(q.ctl[F_SIZE_LO +: 2]);
    assign c_mode    = q.ctl[F_MODE_LO +: 2];
    assign c_sstep   = q.ctl[F_SSTEP_LO +: 2];
    assign c_dstep   = q.ctl[F_DSTEP_LO +: 2];
    assign c_wrapsrc = q.ctl[F_WRAPSRC];
    assign link_take = q.ctl[F_LINK] && (!q.ctl[F_LINKZ] || q.hit0);

    xde_count_unit #(.CNT_W(CNT_W)) u_cnt (
        .mode_i  (c_mode),
        .cnt_a_i (q.cnt_a),
        .cnt_b_i (q.cnt_b),
        .blk_i   (q.blk),
        .cnt_a_o (u_cnt_a),
        .cnt_b_o (u_cnt_b),
        .blk_o   (u_blk),
        .rcnt_o  (u_rcnt),
        .wrap_o  (u_wrap),
        .zero_o  (u_zero),
        .last_o  (u_last)
    );

    for (genvar g = 0; g < 2; g++) begin : g_side
        logic [ADDR_W-1:0] a_in, a_out;
        logic [1:0]        stp;
        logic              wr;
        assign a_in = (g == 0) ? q.sar : q.dar;
        assign stp  = (g == 0) ? c_sstep : c_dstep;
        assign wr   = u_wrap && ((g == 0) ? c_wrapsrc : !c_wrapsrc);
        xde_addr_unit #(.ADDR_W(ADDR_W), .RCNT_W(BW)) u_addr (
            .addr_i (a_in),
            .step_i (stp),
            .size_i (c_size),
            .wrap_i (wr),
            .rcnt_i (u_rcnt),
            .addr_o (a_out)
        );
    end

    assign u_sar = g_side[0].a_out;
    assign u_dar = g_side[1].a_out;

    always_comb begin
        d         = q;
        mem_req   = (q.st != ST_IDLE);
        mem_we    = 1'b0;
        mem_size  = 2'd2;
        mem_addr  = q.ptr + (ADDR_W'(q.idx) << 2);
        mem_wdata = q.data;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.ptr = start_ptr;
                    d.idx = '0;
                    d.st  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    d.idx = q.idx + 1'b1;
                    unique case (q.idx)
                        2'd0: d.ctl = mem_rdata[CTL_W-1:0];
                        2'd1: d.sar = mem_rdata[ADDR_W-1:0];
                        2'd2: d.dar = mem_rdata[ADDR_W-1:0];
                        default: begin
                            d.cnt_a = mem_rdata[CNT_W-1:0];
                            d.cnt_b = mem_rdata[2*CNT_W-1:CNT_W];
                            d.blk   = (mem_rdata[CNT_W-1:HALF] == '0) ?
                                      {1'b1, {HALF{1'b0}}} :
                                      {1'b0, mem_rdata[CNT_W-1:HALF]};
                            d.hit0  = 1'b0;
                            d.st    = ST_READ;
                        end
                    endcase
                end
            end
            ST_READ: begin
                mem_size = c_size;
                mem_addr = q.sar;
                if (mem_ack) begin
                    d.data = mem_rdata;
                    d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_we   = 1'b1;
                mem_size = c_size;
                mem_addr = q.dar;
                if (mem_ack) begin
                    d.sar   = u_sar;
                    d.dar   = u_dar;
                    d.cnt_a = u_cnt_a;
                    d.cnt_b = u_cnt_b;
                    d.blk   = u_blk;
                    if (u_last) begin
                        d.hit0 = u_zero;
                        d.idx  = '0;
                        d.st   = ST_WBACK;
                    end else begin
                        d.st = ST_READ;
                    end
                end
            end
            ST_WBACK: begin
                mem_we   = 1'b1;
                mem_addr = q.ptr + (ADDR_W'(q.idx) << 2) + ADDR_W'(4);
                unique case (q.idx)
                    2'd0:    mem_wdata = 32'(q.sar);
                    2'd1:    mem_wdata = 32'(q.dar);
                    default: mem_wdata = {q.cnt_b, q.cnt_a};
                endcase
                if (mem_ack) begin
                    d.idx = q.idx + 1'b1;
                    if (q.idx == 2'd2) begin
                        d.idx = '0;
                        if (link_take) begin
                            d.ptr = q.ptr + ADDR_W'(DESC_BYTES);
                            d.st  = ST_FETCH;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);
endmodule

// File: rtl/xde_engine_chk.sv
module xde_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_ptr,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [1:0]        mem_size,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!busy && !mem_req)); // R1

    AST_FIRST_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we && mem_size == 2'd2 && mem_addr == $past(start_ptr))); // R2

    AST_BUSY_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ack) |=> busy); // R2

    AST_LAST_IS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(mem_ack && mem_we && mem_size == 2'd2)); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_size) && $stable(mem_wdata))); // R9

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !mem_ack) |=> $stable(mem_addr)); // R10
endmodule

bind xde_engine xde_engine_chk #(.ADDR_W(ADDR_W)) u_xde_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_ptr (start_ptr),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/test_xde_engine.sv
`timescale 1ns/1ps
module test_xde_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic        busy, mem_req, mem_we, mem_ack = 1'b0;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

    int n_run = 0, n_fail = 0, n_acks = 0;
    logic [7:0] mem [0:1023];
    int lat_cnt = 0, lat_seq = 0;

    always #2 clk = ~clk;

    xde_engine i_xde_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] rd_elem(input int a, input int sz);
        logic [31:0] r = '0;
        for (int i = 0; i < (1 << sz); i++) r |= 32'(mem[(a + i) & 1023]) << (8 * i);
        return r;
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 3 + 1) & 255);
    endfunction

    function automatic logic [31:0] pat_elem(input int a, input int sz);
        logic [31:0] r = '0;
        for (int i = 0; i < (1 << sz); i++) r |= 32'(pat(a + i)) << (8 * i);
        return r;
    endfunction

    // behavioural memory, acknowledge latency cycles through 0..2 (R9)
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (lat_cnt != 0) begin
                lat_cnt <= lat_cnt - 1;
            end else begin
                if (mem_we) begin
                    for (int i = 0; i < (1 << mem_size); i++)
                        mem[(int'(mem_addr) + i) & 1023] = mem_wdata[8*i +: 8];
                end else begin
                    mem_rdata <= rd_elem(int'(mem_addr), int'(mem_size));
                end
                mem_ack <= 1'b1;
                n_acks  = n_acks + 1;
                lat_seq <= lat_seq + 1;
                lat_cnt <= (lat_seq + 1) % 3;
            end
        end
    end

    task automatic put32(input int a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[(a + i) & 1023] = v[8*i +: 8];
    endtask

    task automatic put_desc(input int a, input logic [31:0] c, s, dd, n);
        put32(a, c); put32(a + 4, s); put32(a + 8, dd); put32(a + 12, n);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reset_mem();
        for (int a = 0; a < 1024; a++) mem[a] = (a >= 256 && a < 512) ? pat(a) : 8'h00;
    endtask

    task automatic run(input int ptr);
        @(negedge clk);
        start = 1'b1; start_ptr = 32'(ptr);
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    typedef struct packed {
        logic [31:0] ctl, src, dst, cnt, esar, edar, ecnt, caddr, cfrom;
        logic [1:0]  csz;
    } vec_t;

    // ctl: size[1:0] sstep[3:2] dstep[5:4] mode[7:6] wrapsrc[8]
    localparam vec_t VEC [8] = '{
        '{32'h014, 32'h110, 32'h220, 32'h00000005, 32'h111, 32'h221, 32'h00000004, 32'h220, 32'h110, 2'd0}, // R3 R4
        '{32'h009, 32'h120, 32'h230, 32'h00000000, 32'h11E, 32'h230, 32'h0000FFFF, 32'h230, 32'h120, 2'd1}, // R3 R4
        '{32'h022, 32'h140, 32'h240, 32'h00000001, 32'h140, 32'h23C, 32'h00000000, 32'h240, 32'h140, 2'd2}, // R3 R4
        '{32'h154, 32'h150, 32'h250, 32'h00000401, 32'h14D, 32'h251, 32'h00000404, 32'h250, 32'h150, 2'd0}, // R5
        '{32'h065, 32'h160, 32'h260, 32'h00000202, 32'h162, 32'h25E, 32'h00000201, 32'h260, 32'h160, 2'd1}, // R5
        '{32'h052, 32'h170, 32'h270, 32'h00000301, 32'h170, 32'h268, 32'h00000303, 32'h270, 32'h170, 2'd2}, // R5
        '{32'h094, 32'h180, 32'h280, 32'h00030400, 32'h184, 32'h280, 32'h00020400, 32'h283, 32'h183, 2'd0}, // R6
        '{32'h195, 32'h190, 32'h290, 32'h00010300, 32'h190, 32'h296, 32'h00000300, 32'h294, 32'h194, 2'd1}  // R6
    };

    function automatic string vtag(input logic [31:0] c);
        case (c[7:6])
            2'd1:    return "R5";
            2'd2:    return "R6";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        reset_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 mem_req", 32'(mem_req), 0);

        for (int v = 0; v < 8; v++) begin
            reset_mem();
            put_desc(0, VEC[v].ctl, VEC[v].src, VEC[v].dst, VEC[v].cnt);
            run(0);
            chk({"R3 sar ", vtag(VEC[v].ctl)}, rd_elem(4, 2), VEC[v].esar);
            chk({"R3 dar ", vtag(VEC[v].ctl)}, rd_elem(8, 2), VEC[v].edar);
            chk({vtag(VEC[v].ctl), " count"}, rd_elem(12, 2), VEC[v].ecnt);
            chk({vtag(VEC[v].ctl), " data"}, rd_elem(int'(VEC[v].caddr), int'(VEC[v].csz)),
                pat_elem(int'(VEC[v].cfrom), int'(VEC[v].csz)));
        end

        // R6: block size 0 means 256, block count 0 means 65536
        reset_mem();
        put_desc(0, 32'h094, 32'h100, 32'h200, 32'h0);
        run(0);
        chk("R6 size0 sar", rd_elem(4, 2), 32'h200);
        chk("R6 size0 dar", rd_elem(8, 2), 32'h200);
        chk("R6 size0 count", rd_elem(12, 2), 32'hFFFF0000);
        chk("R6 size0 last", rd_elem(32'h2FF, 0), 32'(pat(32'h1FF)));

        // R2: busy the cycle after start, control word untouched
        reset_mem();
        put_desc(0, 32'h014, 32'h110, 32'h210, 32'h3);
        @(negedge clk); start = 1'b1; start_ptr = 32'h0;
        @(negedge clk); start = 1'b0;
        chk("R2 busy after start", 32'(busy), 1);
        while (busy) @(negedge clk);
        chk("R2 ctl untouched", rd_elem(0, 2), 32'h014);

        // R7 chain, R9 access count
        reset_mem();
        put_desc(0,  32'h214, 32'h1A0, 32'h2A0, 32'h3);
        put_desc(16, 32'h014, 32'h1B0, 32'h2B0, 32'h2);
        n_acks = 0;
        run(0);
        chk("R7 first count", rd_elem(12, 2), 32'h2);
        chk("R7 linked count", rd_elem(28, 2), 32'h1);
        chk("R7 linked data", rd_elem(32'h2B0, 0), 32'(pat(32'h1B0)));
        chk("R9 access count", 32'(n_acks), 18);

        // R8 link only on zero
        reset_mem();
        put_desc(0,  32'h614, 32'h1C0, 32'h2C0, 32'h2);
        put_desc(16, 32'h014, 32'h1D0, 32'h2D0, 32'h2);
        n_acks = 0;
        run(0);
        chk("R8 nonzero count", rd_elem(12, 2), 32'h1);
        chk("R8 no link count", rd_elem(28, 2), 32'h2);
        chk("R8 no link data", rd_elem(32'h2D0, 0), 0);
        chk("R9 single access count", 32'(n_acks), 9);
        run(0);
        chk("R8 zero count", rd_elem(12, 2), 32'h0);
        chk("R8 link count", rd_elem(28, 2), 32'h1);
        chk("R8 link data", rd_elem(32'h2D0, 0), 32'(pat(32'h1D0)));

        // R10: start while busy and on the final write-back acknowledge
        reset_mem();
        put_desc(0,  32'h014, 32'h110, 32'h210, 32'h5);
        put_desc(64, 32'h014, 32'h120, 32'h220, 32'h7);
        @(negedge clk); start = 1'b1; start_ptr = 32'h0;
        @(negedge clk); start = 1'b1; start_ptr = 32'h40;
        @(negedge clk); start = 1'b0;
        while (!(mem_ack && mem_we && mem_addr == 32'h0C)) @(negedge clk);
        start = 1'b1; start_ptr = 32'h40;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 busy", 32'(busy), 0);
        chk("R10 first count", rd_elem(12, 2), 32'h4);
        chk("R10 second untouched", rd_elem(76, 2), 32'h7);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule